// File: doc/BRIEF.md
# Clocked Serial Word Receiver

This block is the receive side of an 8-bit synchronous serial link in which the block is the clock master. While an active-low enable is held low, it generates a shift clock from the system clock through a programmable divider. It samples an NRZ data line into a shift register, most significant bit first. Each complete word moves into a single receive buffer. A ready flag, and optionally an interrupt line, tell the host that a word is waiting there. The host takes the word and acknowledges it with a one-cycle read pulse.

The data line is assumed to change on one edge of the shift clock, and the block samples it on the other edge. An edge-select input picks which edge is which, and it also fixes the level at which the clock rests. The block never overwrites a word that has not been read. If a second word completes while the buffer is still full, the clock stops at its resting level and the word waits in the shift register until the host reads. Raising the enable mid-word stops the clock and forces whatever bits have arrived into the buffer, right-aligned, with a count of valid bits. This gives the host a way to receive words shorter than eight bits.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, `rdy` and `irq` are 0, `rx_data` and `rx_bits` are 0, and `sck` rests at the inverse of `rise_tx`.
- R2: While shifting, every high and every low phase of `sck` lasts exactly `div_val`+1 system clock cycles (`div_val` ≥ 2).
- R3: With `rise_tx`=1, `sck` rests low, and `sd` is sampled on the falling edge of `sck`. With `rise_tx`=0, `sck` rests high and `sd` is sampled on the rising edge. `rise_tx` is changed only while the block is disabled.
- R4: The first bit sampled in a word lands in `rx_data[7]`. A full word is presented with `rx_bits`=8 and `rdy`=1.
- R5: If the host reads each word before the next one completes, reception runs on without pause and the words arrive in order.
- R6: If a word completes while `rdy`=1, the clock stops at its resting level after exactly 16 sample edges counted from enable, and the word is held. On the next read pulse, that word enters the buffer in the same cycle: `rdy` stays 1 and `rx_data` shows the held word one cycle later. Clocking then resumes.
- R7: Raising `en_n` while k bits (1..8) are held returns `sck` to its resting level within one system clock. The buffer is then loaded with those bits in `rx_data[k-1:0]`, with zeros above them, `rx_bits`=k and `rdy`=1, even if the previous word was unread.
- R8: Raising `en_n` when no bits of the current word have been sampled leaves `rx_data`, `rx_bits` and `rdy` unchanged.
- R9: Each load of the buffer sets `irq` only if `irq_en` is 1 in that cycle. `rdy` is set regardless of `irq_en`.
- R10: A `rd_pulse` cycle with no coinciding buffer load clears `rdy` and `irq` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | 1 | Active-low receiver enable |
| rise_tx | input | 1 | 1: line changes on rising edge, sampled on falling; 0: the reverse |
| div_val | input | DIV_W | Half-period of the shift clock minus one, in system clocks |
| irq_en | input | 1 | Enables the interrupt on buffer loads |
| rd_pulse | input | 1 | One-cycle host acknowledge of the buffer |
| sd | input | 1 | Serial data line |
| sck | output | 1 | Generated shift clock |
| rx_data | output | 8 | Receive buffer contents |
| rx_bits | output | 4 | Number of valid bits in the buffer |
| rdy | output | 1 | Buffer holds an unread word |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch on every cycle that no load of the buffer happens while it is full and unacknowledged, unless it is a deactivation. They also check that a stalled receiver sits with the clock at rest and eight bits held, that the bit count never passes eight, and that the interrupt only rises when it is enabled and falls on a read. Only the bench scenarios can show the values that arrive: bit order, the choice of sampling edge under both polarities, the phase length of the clock, the count of sample edges before a stall, and the right-aligned contents of a truncated word.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int SRX_W     = 8;
    localparam int SRX_CNT_W = $clog2(SRX_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STALL = 2'd2
    } srx_state_e;

    typedef struct packed {
        srx_state_e           st;
        logic                 ph;
        logic [SRX_W-1:0]     sh;
        logic [SRX_CNT_W-1:0] cnt;
    } srx_shift_t;

    typedef struct packed {
        logic [SRX_W-1:0]     data;
        logic [SRX_CNT_W-1:0] bits;
        logic                 rdy;
        logic                 irq;
    } srx_buf_t;
endpackage

// File: rtl/srx_divider.sv
module srx_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div_val);
        cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
    import srx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_n,
    input  logic                 tick,
    input  logic                 sd,
    input  logic                 buf_free,
    output logic                 run,
    output logic                 phase,
    output logic                 xfer,
    output logic [SRX_W-1:0]     xdata,
    output logic [SRX_CNT_W-1:0] xbits
);
    localparam logic [SRX_CNT_W-1:0] FULL = SRX_CNT_W'(SRX_W);
    localparam logic [SRX_CNT_W-1:0] LAST = SRX_CNT_W'(SRX_W - 1);

    srx_shift_t       r_d, r_q;
    logic [SRX_W-1:0] shn;

    always_comb begin
        r_d   = r_q;
        xfer  = 1'b0;
        xdata = r_q.sh;
        xbits = r_q.cnt;
        shn   = {r_q.sh[SRX_W-2:0], sd};
        unique case (r_q.st)
            ST_IDLE: begin
                if (!en_n) begin
                    r_d.st  = ST_RUN;
                    r_d.ph  = 1'b0;
                    r_d.sh  = '0;
                    r_d.cnt = '0;
                end
            end
            ST_RUN: begin
                if (en_n) begin
                    r_d.st = ST_IDLE;
                    r_d.ph = 1'b0;
                    xfer   = (r_q.cnt != '0);
                end else if (tick) begin
                    if (!r_q.ph) begin
                        r_d.ph = 1'b1;
                    end else begin
                        r_d.ph = 1'b0;
                        if (r_q.cnt == LAST) begin
                            if (buf_free) begin
                                xfer    = 1'b1;
                                xdata   = shn;
                                xbits   = FULL;
                                r_d.sh  = '0;
                                r_d.cnt = '0;
                            end else begin
                                r_d.sh  = shn;
                                r_d.cnt = FULL;
                                r_d.st  = ST_STALL;
                            end
                        end else begin
                            r_d.sh  = shn;
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                end
            end
            ST_STALL: begin
                if (en_n) begin
                    r_d.st = ST_IDLE;
                    xfer   = 1'b1;
                end else if (buf_free) begin
                    xfer    = 1'b1;
                    r_d.st  = ST_RUN;
                    r_d.sh  = '0;
                    r_d.cnt = '0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        run   = (r_q.st == ST_RUN);
        phase = r_q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, ph: 1'b0, sh: '0, cnt: '0};
        else        r_q <= r_d;
    end

    // R6: a stalled receiver rests its clock and holds a whole word
    a_r6_stall_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STALL) |-> (r_q.ph == 1'b0 && r_q.cnt == FULL));

    // R4: the bit count never passes a whole word
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= FULL);
endmodule

// File: rtl/srx_rxbuf.sv
module srx_rxbuf
    import srx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [SRX_W-1:0]     ldata,
    input  logic [SRX_CNT_W-1:0] lbits,
    input  logic                 irq_en,
    input  logic                 rd_pulse,
    output logic [SRX_W-1:0]     data,
    output logic [SRX_CNT_W-1:0] bits,
    output logic                 rdy,
    output logic                 irq
);
    srx_buf_t b_d, b_q;

    always_comb begin
        b_d     = b_q;
        b_d.rdy = (b_q.rdy && !rd_pulse) || load;
        b_d.irq = (b_q.irq && !rd_pulse) || (load && irq_en);
        if (load) begin
            b_d.data = ldata;
            b_d.bits = lbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign data = b_q.data;
    assign bits = b_q.bits;
    assign rdy  = b_q.rdy;
    assign irq  = b_q.irq;

    // R9: the interrupt rises only after a cycle with irq_en set
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en));
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
    import srx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_n,
    input  logic                 rise_tx,
    input  logic [DIV_W-1:0]     div_val,
    input  logic                 irq_en,
    input  logic                 rd_pulse,
    input  logic                 sd,
    output logic                 sck,
    output logic [SRX_W-1:0]     rx_data,
    output logic [SRX_CNT_W-1:0] rx_bits,
    output logic                 rdy,
    output logic                 irq
);
    logic                 tick, run, phase, xfer, buf_free;
    logic [SRX_W-1:0]     xdata;
    logic [SRX_CNT_W-1:0] xbits;

    assign buf_free = !rdy || rd_pulse;
    assign sck      = phase ^ ~rise_tx;

    srx_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_val (div_val),
        .tick    (tick)
    );

    srx_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_n     (en_n),
        .tick     (tick),
        .sd       (sd),
        .buf_free (buf_free),
        .run      (run),
        .phase    (phase),
        .xfer     (xfer),
        .xdata    (xdata),
        .xbits    (xbits)
    );

    srx_rxbuf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (xfer),
        .ldata    (xdata),
        .lbits    (xbits),
        .irq_en   (irq_en),
        .rd_pulse (rd_pulse),
        .data     (rx_data),
        .bits     (rx_bits),
        .rdy      (rdy),
        .irq      (irq)
    );

    // R6: while enabled, an unread buffer is never loaded again
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !en_n) |-> (!rdy || rd_pulse));

    // R10: an acknowledge with no coinciding load clears flag and request
    a_r10_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && !xfer) |=> (!rdy && !irq));

    // R7: a buffer load on deactivation always carries at least one bit
    a_r7_partial_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && en_n) |-> (xbits != '0));
endmodule

// File: tb/tb_sync_rx_master.sv
`timescale 1ns/1ps
module tb_sync_rx_master;
    localparam int DIV = 3;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       en_n = 1'b1, rise_tx = 1'b1, irq_en = 1'b0, rd_pulse = 1'b0, sd = 1'b0;
    logic [7:0] div_val = 8'(DIV);
    logic       sck, rdy, irq;
    logic [7:0] rx_data;
    logic [3:0] rx_bits;

    int total = 0, bad = 0, cyc = 0;
    logic        armed = 1'b0;
    logic [63:0] stream = '0;
    int idx = 0, samp_cnt = 0;

    always #2.5 clk = ~clk;

    sync_rx_master dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .rise_tx(rise_tx), .div_val(div_val),
        .irq_en(irq_en), .rd_pulse(rd_pulse), .sd(sd), .sck(sck), .rx_data(rx_data),
        .rx_bits(rx_bits), .rdy(rdy), .irq(irq)
    );

    // serial source: drives a new bit on the change edge, counts sample edges
    always @(sck) begin
        if (armed) begin
            if (sck == rise_tx) begin
                #1;
                sd = (idx < 64) ? stream[63-idx] : 1'b0;
                idx++;
            end else begin
                samp_cnt++;
            end
        end
    end

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            report();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic prep(input logic rise, input logic [63:0] s);
        armed = 1'b0;
        @(negedge clk); rise_tx = rise;
        @(negedge clk);
        stream = s; idx = 0; samp_cnt = 0; armed = 1'b1;
    endtask

    task automatic wait_rdy();
        int n = 0;
        while (!rdy && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic ack();
        @(negedge clk); rd_pulse = 1'b1;
        @(negedge clk); rd_pulse = 1'b0;
    endtask

    task automatic t_reset();
        chk(rdy == 0 && irq == 0, "R1 flags", {rdy, irq}, 0);
        chk(rx_data == 0 && rx_bits == 0, "R1 buffer", {rx_data, rx_bits}, 0);
        chk(sck == 1'b0, "R1 sck rest", sck, 0);
    endtask

    // R2, R3, R4, R8: one word, rising change edge; R9 with irq off
    task automatic t_word_rise();
        logic lvl;
        int n;
        prep(1'b1, {8'h35, 56'h0});
        irq_en = 1'b0;
        en_n = 1'b0;
        n = 0;
        while (sck == 1'b0 && n < 100) begin @(negedge clk); n++; end
        lvl = sck;
        n = 0;
        do begin @(negedge clk); n++; end while (sck == lvl && n < 100);
        chk(n == DIV + 1, "R2 high phase", n, DIV + 1);
        lvl = sck;
        n = 0;
        do begin @(negedge clk); n++; end while (sck == lvl && n < 100);
        chk(n == DIV + 1, "R2 low phase", n, DIV + 1);
        wait_rdy();
        chk(rx_data == 8'h35 && rx_bits == 8, "R4 word msb first", rx_data, 8'h35);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        @(negedge clk); en_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rx_data == 8'h35 && rx_bits == 8 && rdy, "R8 empty deact", {rx_data, rx_bits}, {8'h35, 4'd8});
        chk(sck == 1'b0, "R3 rest low", sck, 0);
        ack();
        chk(rdy == 0, "R10 ack clears", rdy, 0);
    endtask

    // R3: falling change edge, sampled on rising; buffer left unread
    task automatic t_word_fall();
        prep(1'b0, {8'hC6, 56'h0});
        chk(sck == 1'b1, "R3 rest high", sck, 1);
        en_n = 1'b0;
        wait_rdy();
        chk(rx_data == 8'hC6 && rx_bits == 8, "R3 rising sample", rx_data, 8'hC6);
        @(negedge clk); en_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sck == 1'b1, "R3 rest high after", sck, 1);
    endtask

    // R7: truncation after five bits overwrites the unread word
    task automatic t_partial();
        prep(1'b1, {8'hA5, 56'h0});
        en_n = 1'b0;
        while (samp_cnt < 5) @(negedge clk);
        en_n = 1'b1;
        @(negedge clk);
        chk(sck == 1'b0, "R7 clock stops", sck, 0);
        chk(rx_data == 8'h14 && rx_bits == 5, "R7 partial", {rx_data, rx_bits}, {8'h14, 4'd5});
        chk(rdy == 1'b1, "R7 rdy", rdy, 1);
        ack();
    endtask

    // R5: three words read in time, no pause
    task automatic t_stream();
        logic [7:0] got [3];
        prep(1'b1, {8'h81, 8'h7E, 8'h5A, 40'h0});
        en_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            wait_rdy();
            got[i] = rx_data;
            ack();
        end
        chk(samp_cnt == 24, "R5 no pause", samp_cnt, 24);
        @(negedge clk); en_n = 1'b1;
        chk(got[0] == 8'h81, "R5 word0", got[0], 8'h81);
        chk(got[1] == 8'h7E, "R5 word1", got[1], 8'h7E);
        chk(got[2] == 8'h5A, "R5 word2", got[2], 8'h5A);
        repeat (3) @(negedge clk);
    endtask

    // R6 stall and R9/R10 interrupt handling
    task automatic t_stall();
        prep(1'b1, {8'hE1, 8'h2D, 8'h96, 40'h0});
        irq_en = 1'b1;
        en_n = 1'b0;
        wait_rdy();
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq set", irq, 1);
        repeat (200) @(negedge clk);
        chk(samp_cnt == 16, "R6 stall count", samp_cnt, 16);
        chk(sck == 1'b0, "R6 rest in stall", sck, 0);
        chk(rx_data == 8'hE1, "R6 no overwrite", rx_data, 8'hE1);
        ack();
        chk(rdy == 1'b1 && rx_data == 8'h2D, "R6 held word", rx_data, 8'h2D);
        ack();
        chk(rdy == 1'b0 && irq == 1'b0, "R10 clear", {rdy, irq}, 0);
        wait_rdy();
        chk(rx_data == 8'h96, "R6 resumed", rx_data, 8'h96);
        @(negedge clk); en_n = 1'b1;
        ack();
        irq_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_word_rise();
        t_word_fall();
        t_partial();
        t_stream();
        t_stall();
        report();
    end
endmodule